// File: doc/BRIEF.md
# Tracking ADC Step Controller

This block is the digital half of a follow-up analog-to-digital converter. It holds an up/down code that feeds an external DAC. It reads one comparator bit, which is high when the DAC output is above the analog input. After each step it waits until the comparator has reported on the new code, then moves the code by one LSB toward the input. The code is never cleared between conversions, so a new conversion starts from the previous result. A small change at the input therefore finishes in a few steps, and conversion time grows with the distance the input has moved.

A conversion begins with a one-cycle `start` while the block is idle. It ends when the code has changed direction twice in a row, which is the one-LSB dither around the input level. It also ends when the next step would leave the code range. The result is the lower of the two dithering codes, and `valid` stays high, holding that result, until the next conversion is accepted. The comparator bit is asynchronous to `clk` and passes through a synchroniser inside the block.

Top module: `tadc_tracker`

## Requirements
- R1: While `rst_n` is low, `dac_code`, `result` and `valid` are all 0.
- R2: `dac_code` changes by at most one LSB per clock. Between two steps there are at least SETTLE cycles: the parameter value, raised to SYNC_STAGES+1 if it is smaller. This is long enough for the comparator to pass through the synchroniser after each step.
- R3: At each decision the code rises by one when `dac_above` is 0 (DAC at or below the input) and falls by one when `dac_above` is 1 (DAC above the input).
- R4: A `start` accepted while idle begins tracking from the code left by the previous conversion. Decisions come every SETTLE cycles, and the first comes SETTLE cycles after the start edge. With the ideal compare `dac_above = (dac_code > v)`, a start code c and 0 <= v < 2^N-1, the number of decisions is v-c+3 when c <= v and c-v+2 when c > v.
- R5: Two direction reversals on consecutive decisions end the conversion without a further step. `result` is the lower of the two dithering codes, which equals v under the ideal compare. `dac_code` remains on the code where the lock was decided: v when coming from below, v+1 when coming from above.
- R6: The code saturates and never wraps. A decision that would step above 2^N-1 or below 0 ends the conversion, with the rail code as `result`. The number of decisions is (2^N-1)-c+1 at the top rail and c+1 at the bottom rail.
- R7: `valid` falls on the edge that accepts `start`. It rises on the edge of the final decision, then stays high with `result` unchanged while the block is idle.
- R8: A `start` during a conversion is ignored: the result and the latency are those of the conversion already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| dac_above | input | 1 | Comparator: 1 when the DAC output is above the input, asynchronous |
| dac_code | output | CODE_W | Code driving the external DAC |
| result | output | CODE_W | Last converted code |
| valid | output | 1 | `result` holds a finished conversion |

## Verification
The embedded properties check the following on every cycle:
- the code moves by at most one LSB per clock;
- the code never wraps past either rail;
- the code holds still while the block is idle;
- a held result sits within one LSB below the DAC code;
- `valid` and the busy state never overlap;
- the pacing timer always enforces a gap after each step.

Only the bench scenarios can show the rest:
- that the direction follows the comparator;
- that tracking resumes from the previous code, through the exact decision counts for moves up, moves down, repeated inputs and both rails;
- that a second `start` in mid-conversion changes nothing;
- that a reset in mid-conversion returns the code to zero.

// File: rtl/tadc_pkg.sv
package tadc_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/tadc_sync.sv
module tadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tadc_pacer.sv
module tadc_pacer #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int W = $clog2(SETTLE + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = W'(SETTLE - 1);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);

  // R2: a step (or start) always opens a wait window
  p_gap_after_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
endmodule

// File: rtl/tadc_lock_det.sv
module tadc_lock_det
  import tadc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      decide,
  input  step_dir_e dir,
  output logic      lock
);
  logic      have_prev_q, have_prev_d;
  step_dir_e prev_dir_q,  prev_dir_d;
  logic      rev_seen_q,  rev_seen_d;
  logic      reversal;

  assign reversal = have_prev_q && (dir != prev_dir_q);
  assign lock     = decide && reversal && rev_seen_q;

  always_comb begin
    have_prev_d = have_prev_q;
    prev_dir_d  = prev_dir_q;
    rev_seen_d  = rev_seen_q;
    if (clear) begin
      have_prev_d = 1'b0;
      prev_dir_d  = DIR_UP;
      rev_seen_d  = 1'b0;
    end else if (decide) begin
      have_prev_d = 1'b1;
      prev_dir_d  = dir;
      rev_seen_d  = reversal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_dir_q  <= DIR_UP;
      rev_seen_q  <= 1'b0;
    end else begin
      have_prev_q <= have_prev_d;
      prev_dir_q  <= prev_dir_d;
      rev_seen_q  <= rev_seen_d;
    end
  end
endmodule

// File: rtl/tadc_tracker.sv
module tadc_tracker
  import tadc_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dac_above,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] result,
  output logic              valid
);
  localparam int SETTLE_MIN = SYNC_STAGES + 1;
  localparam int SETTLE_EFF = (SETTLE_CYC < SETTLE_MIN) ? SETTLE_MIN : SETTLE_CYC;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] result_q, result_d;
  logic              valid_q, valid_d;
  logic              busy_q, busy_d;

  logic      above_s;
  logic      ready;
  logic      accept;
  logic      decide;
  logic      lock;
  logic      at_rail;
  step_dir_e dir;

  tadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dac_above),
    .q     (above_s)
  );

  tadc_pacer #(.SETTLE(SETTLE_EFF)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept || decide),
    .ready (ready)
  );

  tadc_lock_det u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .decide (decide),
    .dir    (dir),
    .lock   (lock)
  );

  assign accept  = start && !busy_q;
  assign decide  = busy_q && ready;
  assign dir     = above_s ? DIR_DOWN : DIR_UP;
  assign at_rail = (dir == DIR_UP) ? (code_q == CODE_MAX) : (code_q == '0);

  always_comb begin
    code_d   = code_q;
    result_d = result_q;
    valid_d  = valid_q;
    busy_d   = busy_q;
    if (accept) begin
      busy_d  = 1'b1;
      valid_d = 1'b0;
    end else if (decide) begin
      if (at_rail) begin
        busy_d   = 1'b0;
        valid_d  = 1'b1;
        result_d = code_q;
      end else if (lock) begin
        busy_d   = 1'b0;
        valid_d  = 1'b1;
        result_d = (dir == DIR_UP) ? code_q : code_q - 1'b1;
      end else begin
        code_d = (dir == DIR_UP) ? code_q + 1'b1 : code_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      code_q   <= code_d;
      result_q <= result_d;
      valid_q  <= valid_d;
      busy_q   <= busy_d;
    end
  end

  assign dac_code = code_q;
  assign result   = result_q;
  assign valid    = valid_q;

  logic [CODE_W:0] code_wide;
  assign code_wide = {1'b0, code_q};

  // R2: one LSB per clock at most
  p_one_lsb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code_wide == $past(code_wide)) ||
             (code_wide == $past(code_wide) + 1'b1) ||
             (code_wide + 1'b1 == $past(code_wide)));

  // R6: no wrap at either rail
  p_no_wrap_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MAX) |=> (code_q != '0));
  p_no_wrap_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |=> (code_q != CODE_MAX));

  // R4: code is retained while idle
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(code_q));

  // R5: a held result is the code or one below it
  p_result_near_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (result_q == code_q) || (result_q + 1'b1 == code_q));

  // R7: valid never overlaps a running conversion
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && busy_q));
endmodule

// File: tb/tb_tadc_tracker.sv
module tb_tadc_tracker;
  localparam int CODE_W = 6;
  localparam int SETTLE = 3;
  localparam int MAXV   = (1 << CODE_W) - 1;

  typedef struct {
    int res;
    int lat;
    int code;
    int kind;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              dac_above;
  logic [CODE_W-1:0] dac_code;
  logic [CODE_W-1:0] result;
  logic              valid;

  int   vin = 0;
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  int   model_code = 0;
  exp_t expq[$];

  assign dac_above = (int'(dac_code) > vin);

  tadc_tracker #(.CODE_W(CODE_W), .SYNC_STAGES(2), .SETTLE_CYC(SETTLE)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dac_above (dac_above),
    .dac_code  (dac_code),
    .result    (result),
    .valid     (valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input int c, input int v, input int kind);
    exp_t e;
    int   d;
    e.kind = kind;
    if (v >= MAXV) begin
      e.res = MAXV; d = MAXV - c + 1; e.code = MAXV; e.kind = 1;
    end else if (v < 0) begin
      e.res = 0; d = c + 1; e.code = 0; e.kind = 1;
    end else if (c <= v) begin
      e.res = v; d = v - c + 3; e.code = v;
    end else begin
      e.res = v; d = c - v + 2; e.code = v + 1;
    end
    e.lat = d * SETTLE;
    return e;
  endfunction

  // Monitor: scoreboard side
  bit in_conv = 1'b0;
  bit prev_valid = 1'b0;
  int t0 = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_conv = 1'b0;
    end else begin
      if (start && !in_conv) begin
        in_conv = 1'b1;
        t0 = cyc;
      end
      if (valid && !prev_valid && in_conv) begin
        in_conv = 1'b0;
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected result", int'(result), -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.kind == 1) begin
            chk(int'(result) == e.res, "R6 rail result", int'(result), e.res);
            chk(int'(dac_code) == e.code, "R6 rail code", int'(dac_code), e.code);
          end else begin
            chk(int'(result) == e.res, "R5 locked result", int'(result), e.res);
            chk(int'(dac_code) == e.code, "R3 R5 code at lock", int'(dac_code), e.code);
          end
          if (e.kind == 2)
            chk(cyc - t0 - 1 == e.lat, "R8 latency with ignored start", cyc - t0 - 1, e.lat);
          else
            chk(cyc - t0 - 1 == e.lat, "R2 R4 latency", cyc - t0 - 1, e.lat);
        end
      end
    end
    prev_valid = valid;
  end

  // Driver
  task automatic convert(input int v, input bit restart_mid, input bit hold_chk);
    exp_t e;
    int   n;
    int   held;
    @(posedge clk); #1 vin = v;
    repeat (4) @(posedge clk);
    e = model(model_code, v, restart_mid ? 2 : 0);
    expq.push_back(e);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R7 valid cleared on start", int'(valid), 0);
    if (restart_mid) begin
      repeat (4) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    n = 0;
    while (!valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!valid) chk(1'b0, "R4 conversion timeout", n, e.lat);
    model_code = e.code;
    if (hold_chk) begin
      held = int'(result);
      repeat (6) @(negedge clk);
      chk(valid == 1'b1, "R7 valid held", int'(valid), 1);
      chk(int'(result) == held, "R7 result held", int'(result), held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dac_code == '0, "R1 reset code", int'(dac_code), 0);
    chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    chk(result == '0, "R1 reset result", int'(result), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    convert(20, 1'b0, 1'b0);   // climb from zero
    convert(23, 1'b0, 1'b1);   // short climb, R4 retained code
    convert(9,  1'b0, 1'b0);   // descend
    convert(9,  1'b0, 1'b0);   // same input again
    convert(10, 1'b0, 1'b0);
    convert(70, 1'b1, 1'b0);   // top rail, extra start ignored (R8)
    convert(62, 1'b0, 1'b0);   // just below the top rail
    convert(-1, 1'b0, 1'b0);   // bottom rail
    convert(0,  1'b0, 1'b0);
    convert(40, 1'b0, 1'b1);

    // R1: reset in mid-conversion
    @(posedge clk); #1 vin = 5;
    repeat (4) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(dac_code == '0, "R1 mid-run reset code", int'(dac_code), 0);
    chk(valid == 1'b0, "R1 mid-run reset valid", int'(valid), 0);
    chk(result == '0, "R1 mid-run reset result", int'(result), 0);
    model_code = 0;
    @(posedge clk); #1 rst_n = 1'b1;

    convert(5, 1'b0, 1'b0);    // tracking restarts from zero

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R5 all results seen", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule